// File: doc/BRIEF.md
# Event Priority Queue with Multi-Insert and Tag Invalidation

This block keeps the pending events of a discrete-event simulation pipeline in time order on chip. Each stored event carries a 32-bit timestamp and two 12-bit particle identifiers. The earliest event is always visible at the head, and the consumer removes it by raising a ready line. The queue sustains one removal per cycle.

In the same cycle as a removal, the producer can offer new events on six insertion lanes. The queue accepts up to four of them and places each one in time order. An invalidation broadcast carries a particle tag. In a single cycle it kills every stored event whose first or second identifier equals that tag, however many there are.

Killed events leave holes in the slot array. The queue does not close these holes at once. Each cycle, every live entry advances past at most two holes, so a run of holes drains over a few cycles and the ordering of the survivors is kept.

Top module: `event_scrunch_queue`

## Requirements
- R1: After reset the queue holds no event: `headValid` is 0, and `insStall` is 0 while no lane is offered.
- R2: While an event is stored and the head slot is not being killed, `headValid` is 1 and the head outputs show the event with the smallest timestamp. When `headValid` and `deqReady` are both 1 at a clock edge, that event is removed.
- R3: Accepted insertions are placed in timestamp order, whatever their lane order. An event inserted into an empty queue appears at the head in the next cycle.
- R4: Equal timestamps leave in arrival order. An event already stored leaves before one inserted later. Among lanes accepted in the same cycle, the lower lane index leaves first.
- R5: When more than four lanes are offered, only the four lowest-indexed offered lanes are accepted. `insStall` is 1 in that cycle, and the other lanes' events never appear.
- R6: The queue holds at most 32 events. Offered lanes beyond the free slot count are rejected, lowest index first accepted, and `insStall` is 1. A removal in the same cycle frees one slot for that cycle's insertions.
- R7: With `killValid` at 1, every stored event whose first or second identifier equals `killTag` is discarded at the clock edge. If the head is among them, `headValid` is 0 in that cycle and the head is not removed. Events inserted in the same cycle are not affected.
- R8: Holes left by discarded events are closed by advancing each entry at most two slots per cycle. No surviving event is lost or duplicated, and the survivors leave in timestamp order.
- R9: Inserting one event and removing one event every cycle gives a valid head in every cycle, without bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 6 | Per-lane insertion offer |
| insTime | input | 6x32 | Per-lane event timestamp |
| insIdA | input | 6x12 | Per-lane first particle identifier |
| insIdB | input | 6x12 | Per-lane second particle identifier |
| killValid | input | 1 | Invalidation broadcast strobe |
| killTag | input | 12 | Particle tag to invalidate |
| deqReady | input | 1 | Consumer takes the head this cycle |
| headValid | output | 1 | Head event present and live |
| headTime | output | 32 | Head event timestamp |
| headIdA | output | 12 | Head event first identifier |
| headIdB | output | 12 | Head event second identifier |
| insStall | output | 1 | Some offered lane was not accepted |

## Verification
A wrong slot state shows at the head port within one cycle. A misplaced insertion or a broken tie changes the head identifier at the next removal that reaches it, so the bench checks the second identifier as well as the timestamp. A faulty compaction shows as a missing, repeated or out-of-order survivor once the queue is drained after a mass kill. A wrong free-slot count shows on `insStall` in the same cycle, and the dropped or extra event shows later in the drained stream.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int TIME_W = 32;
  localparam int ID_W   = 12;

  typedef struct packed {
    logic              valid;
    logic [TIME_W-1:0] stamp;
    logic [ID_W-1:0]   idA;
    logic [ID_W-1:0]   idB;
  } evEntry_t;

  typedef struct packed {
    logic popHead;   // head leaves at this edge
    logic insertEn;  // at least one lane is admitted
  } pqStrobe_t;
endpackage

// File: rtl/spq_ctrl.sv
module spq_ctrl
  import spq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int LANES   = 6,
  parameter int MAX_INS = 4,
  parameter int PW      = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] insValid,
  input  logic             deqReady,
  input  logic             headLive,
  input  logic [PW-1:0]    tailPos,
  output pqStrobe_t        strb,
  output logic [LANES-1:0] acceptMask,
  output logic             insStall
);
  logic [PW-1:0] freeSlots;
  logic [PW-1:0] budget;
  logic [PW-1:0] taken;

  always_comb begin
    freeSlots = PW'(DEPTH) - tailPos;
    budget    = (freeSlots < PW'(MAX_INS)) ? freeSlots : PW'(MAX_INS);
    taken     = '0;
    for (int n = 0; n < LANES; n++) begin
      acceptMask[n] = 1'b0;
      if (insValid[n] && (taken < budget)) begin
        acceptMask[n] = 1'b1;
        taken         = taken + 1'b1;
      end
    end
    insStall      = |(insValid & ~acceptMask);
    strb.popHead  = headLive & deqReady;
    strb.insertEn = |acceptMask;
  end

  AST_ACCEPT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    $countones(acceptMask) <= MAX_INS); // R5
  AST_ACCEPT_OFFERED: assert property (@(posedge clk) disable iff (!rstN)
    (acceptMask & ~insValid) == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    $countones(acceptMask) <= (DEPTH - int'(tailPos))); // R6
endmodule

// File: rtl/spq_datapath.sv
module spq_datapath
  import spq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LANES = 6,
  parameter int PW    = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pqStrobe_t                    strb,
  input  logic [LANES-1:0]             acceptMask,
  input  logic [LANES-1:0][TIME_W-1:0] insTime,
  input  logic [LANES-1:0][ID_W-1:0]   insIdA,
  input  logic [LANES-1:0][ID_W-1:0]   insIdB,
  input  logic                         killValid,
  input  logic [ID_W-1:0]              killTag,
  output logic                         headLive,
  output evEntry_t                     headEntry,
  output logic [PW-1:0]                tailPos
);
  evEntry_t      slot    [DEPTH];
  evEntry_t      nxt     [DEPTH];
  evEntry_t      newEnt  [LANES];
  logic [PW-1:0] qPos    [DEPTH];
  logic [PW-1:0] dest    [DEPTH];
  logic [PW-1:0] newPos  [LANES];
  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] keep;

  // associative invalidation against the broadcast tag
  always_comb begin
    for (int j = 0; j < DEPTH; j++) begin
      live[j] = slot[j].valid &&
                !(killValid && ((slot[j].idA == killTag) || (slot[j].idB == killTag)));
    end
  end

  assign headLive  = live[0];
  assign headEntry = slot[0];

  // survivors and their scrunched positions (advance by at most two)
  always_comb begin
    logic [1:0]    holes;
    logic [PW-1:0] tail;
    keep    = live;
    keep[0] = live[0] & ~strb.popHead;
    holes   = '0;
    tail    = '0;
    for (int j = 0; j < DEPTH; j++) begin
      qPos[j] = PW'(j) - PW'(holes);
      if (keep[j]) tail = qPos[j] + 1'b1;
      if (!keep[j] && (holes != 2'd2)) holes = holes + 2'd1;
    end
    tailPos = tail;
  end

  // destinations of survivors and new entries
  always_comb begin
    logic [PW-1:0] rank;
    logic [PW-1:0] base;
    logic [PW-1:0] bump;
    for (int n = 0; n < LANES; n++) begin
      newEnt[n] = '{valid: 1'b1, stamp: insTime[n], idA: insIdA[n], idB: insIdB[n]};
      rank = '0;
      for (int m = 0; m < LANES; m++) begin
        if (acceptMask[m] && ((insTime[m] < insTime[n]) ||
                              ((insTime[m] == insTime[n]) && (m < n))))
          rank = rank + 1'b1;
      end
      base = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (keep[j] && (slot[j].stamp <= insTime[n])) base = qPos[j] + 1'b1;
      end
      newPos[n] = base + rank;
    end
    for (int j = 0; j < DEPTH; j++) begin
      bump = '0;
      for (int n = 0; n < LANES; n++) begin
        if (acceptMask[n] && (insTime[n] < slot[j].stamp)) bump = bump + 1'b1;
      end
      dest[j] = qPos[j] + bump;
    end
  end

  // gather: each slot picks the one entry aimed at it
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      nxt[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if (keep[j] && (dest[j] == PW'(i))) nxt[i] = slot[j];
      end
      for (int n = 0; n < LANES; n++) begin
        if (strb.insertEn && acceptMask[n] && (newPos[n] == PW'(i))) nxt[i] = newEnt[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) slot[i] <= '0;
      else       slot[i] <= nxt[i];
    end
  end

  // checker state and assertions
  logic [ID_W-1:0]  killTagQ;
  logic [DEPTH-1:0] validVec;
  logic             residual;
  int               expCnt;

  always_ff @(posedge clk) begin
    if (!rstN) killTagQ <= '0;
    else       killTagQ <= killTag;
  end

  always_comb begin
    residual = 1'b0;
    for (int j = 0; j < DEPTH; j++) begin
      validVec[j] = slot[j].valid;
      if (slot[j].valid && ((slot[j].idA == killTagQ) || (slot[j].idB == killTagQ)))
        residual = 1'b1;
    end
    expCnt = $countones(keep) + $countones(acceptMask);
  end

  generate
    for (genvar g = 0; g < DEPTH - 1; g++) begin : g_order
      AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
        (slot[g].valid && slot[g+1].valid) |-> (slot[g].stamp <= slot[g+1].stamp)); // R2
    end
  endgenerate

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(validVec) == $past(expCnt))); // R8
  AST_KILL_GONE: assert property (@(posedge clk) disable iff (!rstN)
    (killValid && !strb.insertEn) |=> !residual); // R7
endmodule

// File: rtl/event_scrunch_queue.sv
module event_scrunch_queue
  import spq_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int LANES   = 6,
  parameter int MAX_INS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LANES-1:0]             insValid,
  input  logic [LANES-1:0][TIME_W-1:0] insTime,
  input  logic [LANES-1:0][ID_W-1:0]   insIdA,
  input  logic [LANES-1:0][ID_W-1:0]   insIdB,
  input  logic                         killValid,
  input  logic [ID_W-1:0]              killTag,
  input  logic                         deqReady,
  output logic                         headValid,
  output logic [TIME_W-1:0]            headTime,
  output logic [ID_W-1:0]              headIdA,
  output logic [ID_W-1:0]              headIdB,
  output logic                         insStall
);
  localparam int PW = $clog2(DEPTH + LANES + 1) + 1;

  pqStrobe_t        strb;
  logic [LANES-1:0] acceptMask;
  logic             headLive;
  logic [PW-1:0]    tailPos;
  evEntry_t         headEntry;

  spq_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .MAX_INS(MAX_INS), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .deqReady(deqReady),
    .headLive(headLive), .tailPos(tailPos), .strb(strb),
    .acceptMask(acceptMask), .insStall(insStall)
  );

  spq_datapath #(.DEPTH(DEPTH), .LANES(LANES), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .acceptMask(acceptMask),
    .insTime(insTime), .insIdA(insIdA), .insIdB(insIdB),
    .killValid(killValid), .killTag(killTag),
    .headLive(headLive), .headEntry(headEntry), .tailPos(tailPos)
  );

  assign headValid = headLive;
  assign headTime  = headEntry.stamp;
  assign headIdA   = headEntry.idA;
  assign headIdB   = headEntry.idB;
endmodule

// File: tb/event_scrunch_queue_bench.sv
module event_scrunch_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NL-1:0] insValid = '0;
  logic [NL-1:0][31:0] insTime = '0;
  logic [NL-1:0][11:0] insIdA = '0;
  logic [NL-1:0][11:0] insIdB = '0;
  logic killValid = 1'b0;
  logic [11:0] killTag = '0;
  logic deqReady = 1'b0;
  logic headValid, insStall;
  logic [31:0] headTime;
  logic [11:0] headIdA, headIdB;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_scrunch_queue u_event_scrunch_queue (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insTime(insTime),
    .insIdA(insIdA), .insIdB(insIdB), .killValid(killValid), .killTag(killTag),
    .deqReady(deqReady), .headValid(headValid), .headTime(headTime),
    .headIdA(headIdA), .headIdB(headIdB), .insStall(insStall)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    insValid = '0; insTime = '0; insIdA = '0; insIdB = '0;
    killValid = 1'b0; killTag = '0; deqReady = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); idle(); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(headValid == 1'b0, "R1 head after reset", headValid, 0);
    chk(insStall == 1'b0, "R1 stall after reset", insStall, 0);
  endtask

  // idA = time low bits, idB = {step, lane}
  typedef struct packed {
    logic [5:0] mask;
    logic [15:0] t0, t1, t2, t3;
    logic deq, killEn;
    logic [11:0] tag;
    logic expV;
    logic [15:0] expT;
    logic [11:0] expB;
    logic expS;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b0, 12'h000, 1'b0, 16'd0, 12'h000, 1'b0},  // R1 empty
    '{6'b001111, 16'd40, 16'd10, 16'd30, 16'd20, 1'b0, 1'b0, 12'h000, 1'b0, 16'd0, 12'h000, 1'b0},  // R3 four at once
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd10, 12'h011, 1'b0},  // R3 sorted head
    '{6'b000011, 16'd25, 16'd5, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd20, 12'h013, 1'b0},  // R2
    '{6'b111111, 16'd50, 16'd50, 16'd7, 16'd60, 1'b0, 1'b0, 12'h000, 1'b1, 16'd5, 12'h031, 1'b1},  // R5 six offered
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd5, 12'h031, 1'b0},  // R2 held head
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd7, 12'h042, 1'b0},  // R3
    '{6'b000001, 16'd25, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd25, 12'h030, 1'b0},  // R4 stored first
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd25, 12'h070, 1'b0},  // R4
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd30, 12'h012, 1'b0},  // R2
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd40, 12'h010, 1'b0},  // R2
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd50, 12'h040, 1'b0},  // R4 lane order
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd50, 12'h041, 1'b0},  // R4
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b1, 12'h03C, 1'b0, 16'd0, 12'h000, 1'b0},  // R7 head killed
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b0, 16'd0, 12'h000, 1'b0},  // R5 rejected lanes absent
    '{6'b000001, 16'd9, 16'd0, 16'd0, 16'd0, 1'b0, 1'b1, 12'h009, 1'b0, 16'd0, 12'h000, 1'b0},  // R7 insert spared
    '{6'b000000, 16'd0, 16'd0, 16'd0, 16'd0, 1'b1, 1'b0, 12'h000, 1'b1, 16'd9, 12'h0F0, 1'b0}   // R7
  };

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all-R actual=20000 cycles expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int got;
    doReset();

    // table walk
    for (int k = 0; k < 17; k++) begin
      vec_t v;
      v = VEC[k];
      @(negedge clk);
      idle();
      for (int n = 0; n < NL; n++) begin
        logic [31:0] t;
        case (n)
          0: t = 32'(v.t0);
          1: t = 32'(v.t1);
          2: t = 32'(v.t2);
          3: t = 32'(v.t3);
          default: t = 32'(100 + n);
        endcase
        insTime[n] = t;
        insIdA[n]  = t[11:0];
        insIdB[n]  = {4'(k), 4'(n)} | 12'h000;
        insIdB[n]  = 12'((k << 4) | n);
      end
      insValid  = v.mask;
      deqReady  = v.deq;
      killValid = v.killEn;
      killTag   = v.tag;
      #1;
      chk(headValid == v.expV, $sformatf("R2 head valid step %0d", k), headValid, v.expV);
      if (v.expV) begin
        chk(headTime == 32'(v.expT), $sformatf("R2 head time step %0d", k), headTime, v.expT);
        chk(headIdB == v.expB, $sformatf("R4 head idB step %0d", k), headIdB, v.expB);
      end
      chk(insStall == v.expS, $sformatf("R5 stall step %0d", k), insStall, v.expS);
    end

    // R6 capacity
    doReset();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); idle();
      for (int n = 0; n < 4; n++) begin
        insValid[n] = 1'b1; insTime[n] = 32'(100 + 4*c + n);
        insIdA[n] = 12'(100 + 4*c + n);
      end
      #1;
      chk(insStall == 1'b0, "R6 fill no stall", insStall, 0);
    end
    @(negedge clk); idle();
    insValid[0] = 1'b1; insTime[0] = 32'd999; insIdA[0] = 12'd999;
    #1;
    chk(insStall == 1'b1, "R6 full stall", insStall, 1);
    @(negedge clk); idle();
    insValid[0] = 1'b1; insTime[0] = 32'd50; insIdA[0] = 12'd50;
    insValid[1] = 1'b1; insTime[1] = 32'd51; insIdA[1] = 12'd51;
    deqReady = 1'b1;
    #1;
    chk(insStall == 1'b1, "R6 one freed slot stall", insStall, 1);
    chk(headTime == 32'd100, "R6 head while full", headTime, 100);
    for (int e = 0; e < 32; e++) begin
      logic [31:0] want;
      want = (e == 0) ? 32'd50 : 32'(100 + e);
      @(negedge clk); idle(); deqReady = 1'b1;
      #1;
      chk(headValid && headTime == want, "R6 drain order", headTime, want);
    end
    @(negedge clk); idle();
    #1;
    chk(headValid == 1'b0, "R6 drained empty", headValid, 0);

    // R7 mass kill and R8 compaction
    doReset();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); idle();
      for (int n = 0; n < 4; n++) begin
        insValid[n] = 1'b1; insTime[n] = 32'(200 + 4*c + n);
        insIdA[n] = 12'(200 + 4*c + n);
        insIdB[n] = (n % 2 == 0) ? 12'hABC : 12'(4*c + n);
      end
    end
    @(negedge clk); idle(); killValid = 1'b1; killTag = 12'hABC;
    #1;
    chk(headValid == 1'b0, "R7 killed head masked", headValid, 0);
    got = 0;
    for (int w = 0; w < 40; w++) begin
      @(negedge clk); idle(); deqReady = 1'b1;
      #1;
      if (headValid) begin
        chk(headTime == 32'(201 + 2*got), "R8 survivor order", headTime, 201 + 2*got);
        got++;
      end
    end
    chk(got == 6, "R8 survivor count", got, 6);

    // R9 stream
    doReset();
    @(negedge clk); idle();
    insValid[0] = 1'b1; insTime[0] = 32'd300;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk); idle();
      insValid[0] = 1'b1; insTime[0] = 32'(300 + k); deqReady = 1'b1;
      #1;
      chk(headValid && headTime == 32'(300 + k - 1), "R9 one per cycle", headTime, 300 + k - 1);
    end
    @(negedge clk); idle();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule